// File: doc/BRIEF.md
# Multichannel Symbol Stream Aggregator

This block sits between a bank of forward-error-correction encoders and a modulator. The encoders work at one quarter of the fast clock rate. Here that slow rate is an enable that is high on one fast cycle in four, and the block drives it on `slow_en_o`. The channels arrive in groups of four. On a slow cycle any mix of channels in a group may present a symbol, and every one of those symbols must be kept. The block stores each symbol in a one-entry holding register for its channel. It then sends the stored symbols out on a single time-multiplexed stream at the fast rate. Each output cycle is a slot belonging to one channel, and the slots rotate through the active channels in a fixed order.

The block also paces the encoders. Each channel has a fractional phase accumulator, and a per-channel increment sets that channel's symbol rate. The accumulator adds its increment on every fast cycle. Each carry out of the accumulator produces a one-cycle request strobe for that channel's encoder. A channel whose encoder delivers a symbol before the previous one has been sent raises a sticky overflow flag. A clear input resets the flags.

Everything runs in one clock domain. The slow and fast clocks share aligned edges, so the slow domain is modelled as an enable rather than as a separate clock.

Top module: `sym_tdm_aggregator`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `out_valid_o` is 0, `out_data_o` is 0, `ovf_o` is all zero and `sym_strobe_o` is all zero. No strobe is issued while a channel's enable is 0.
- R2: `slow_en_o` is high on exactly one fast cycle in every four. It is first high on the first cycle after reset.
- R3: `out_ch_o` advances by one on every fast cycle. It wraps to 0 after the last active channel. With `cfg_all_i`=1 all NUM_CH channels are active (slot period NUM_CH). With `cfg_all_i`=0 only channels 0 to NUM_CH/2-1 are active (slot period NUM_CH/2).
- R4: A symbol captured for an active, enabled channel is output exactly once, carrying that channel's index and its 8-bit value. This holds even when every channel of a group, or all channels, present data on the same slow cycle. The symbol appears no later than N+1 fast cycles after the capturing edge, where N is the slot period.
- R5: Input valids are sampled only on clock edges where `slow_en_o` is high. A valid presented on any other cycle is ignored.
- R6: When `ch_en_i[c]` is 0, input on channel c is ignored: it is never output and it raises no overflow. In that state the channel's accumulator is held at zero and the channel issues no strobe.
- R7: A strobe is a single-cycle pulse on the carry out of an ACC_W-bit accumulator that adds `rate_inc_i[c]` every fast cycle. Over W cycles a channel issues floor or ceil of W*inc/2^ACC_W strobes. With inc = 2^ACC_W/4 it strobes exactly every fourth cycle.
- R8: If a valid symbol is captured for a channel whose holding register is still full and is not being emitted on that edge, `ovf_o[c]` is set one cycle later and stays set. Only that channel's flag is affected. The newer symbol replaces the held one.
- R9: A cycle with `ovf_clr_i`=1 clears all overflow flags at the next edge, except for a flag being set on that same edge.
- R10: In half mode (`cfg_all_i`=0), input on channels NUM_CH/2 and above is ignored and never output.
- R11: `out_data_o` is 0 on every cycle where `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_all_i | input | 1 | 1: all channels active; 0: lower half only |
| ch_en_i | input | NUM_CH | Per-channel enable |
| rate_inc_i | input | NUM_CH*ACC_W | Per-channel accumulator increment, channel c at bits [c*ACC_W +: ACC_W] |
| ovf_clr_i | input | 1 | Clears the sticky overflow flags |
| in_valid_i | input | NUM_CH | Per-channel symbol valid, sampled when slow_en_o is high |
| in_data_i | input | NUM_CH*SYM_W | Per-channel symbol, channel c at bits [c*SYM_W +: SYM_W], unused upper bits zero |
| slow_en_o | output | 1 | Slow-rate phase enable, high one cycle in four |
| sym_strobe_o | output | NUM_CH | Per-channel symbol request pulse |
| out_valid_o | output | 1 | Current slot carries a symbol |
| out_ch_o | output | CH_W | Channel index of the current slot |
| out_data_o | output | SYM_W | Symbol of the current slot |
| ovf_o | output | NUM_CH | Sticky per-channel overflow flags |

## Verification
`slow_en_o` is combinational from the phase counter, so the bench reads it at the falling edge and drives stimulus that the next rising edge captures. An output slot is registered: a captured symbol cannot show up before the falling edge after the capturing edge, and it must show up within N+1 cycles. For that reason the bench collects every slot over a window of N+4 cycles and checks the counts and values per channel, rather than expecting a symbol in a particular cycle. Overflow flags, the clear and the strobes are each registered once. The bench therefore samples them one falling edge after the edge that causes them. It counts strobes over windows that are whole multiples of the expected period, so that the exact totals are fixed.

// File: rtl/agg_pkg.sv
package agg_pkg;
    // channels carried by one input group
    localparam int CH_PER_BLK = 4;
    // fast cycles per slow-rate cycle
    localparam int PHASE_DIV  = 4;
endpackage

// File: rtl/agg_phase.sv
module agg_phase #(
    parameter int DIV = agg_pkg::PHASE_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic slow_en_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (ph_q.cnt == PW'(DIV - 1)) ph_d.cnt = '0;
        else                          ph_d.cnt = ph_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_d;
    end

    assign slow_en_o = (ph_q.cnt == '0);

    // R2
    slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
        slow_en_o |=> !slow_en_o);
endmodule

// File: rtl/agg_rate_gen.sv
module agg_rate_gen #(
    parameter int NUM_CH = 16,
    parameter int ACC_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       ch_en_i,
    input  logic [NUM_CH*ACC_W-1:0] inc_i,
    output logic [NUM_CH-1:0]       strobe_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        typedef struct packed {
            logic [ACC_W-1:0] acc;
            logic             stb;
        } acc_t;

        acc_t       acc_d, acc_q;
        logic [ACC_W:0] sum_w;

        always_comb begin
            sum_w = {1'b0, acc_q.acc} + {1'b0, inc_i[g*ACC_W +: ACC_W]};
            acc_d = acc_q;
            if (ch_en_i[g]) begin
                acc_d.acc = sum_w[ACC_W-1:0];
                acc_d.stb = sum_w[ACC_W];
            end else begin
                acc_d.acc = '0;
                acc_d.stb = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) acc_q <= '0;
            else     acc_q <= acc_d;
        end

        assign strobe_o[g] = acc_q.stb;

        // R6
        idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
            !ch_en_i[g] |=> !strobe_o[g]);
    end
endmodule

// File: rtl/agg_slot_buf.sv
module agg_slot_buf #(
    parameter int NUM_CH = 16,
    parameter int SYM_W  = 8,
    parameter int CH_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    slow_en_i,
    input  logic                    cfg_all_i,
    input  logic [NUM_CH-1:0]       ch_en_i,
    input  logic [NUM_CH-1:0]       in_valid_i,
    input  logic [NUM_CH*SYM_W-1:0] in_data_i,
    input  logic                    ovf_clr_i,
    output logic                    out_valid_o,
    output logic [CH_W-1:0]         out_ch_o,
    output logic [SYM_W-1:0]        out_data_o,
    output logic [NUM_CH-1:0]       ovf_o
);
    localparam int HALF = NUM_CH / 2;

    typedef struct packed {
        logic [CH_W-1:0]              slot;
        logic [NUM_CH-1:0]            full;
        logic [NUM_CH-1:0][SYM_W-1:0] hold;
        logic [NUM_CH-1:0]            ovf;
        logic                         out_valid;
        logic [CH_W-1:0]              out_ch;
        logic [SYM_W-1:0]             out_data;
    } sb_t;

    sb_t sb_d, sb_q;

    logic [CH_W-1:0]   last_slot;
    logic              emit;
    logic [NUM_CH-1:0] ovf_set;

    always_comb begin
        sb_d      = sb_q;
        last_slot = cfg_all_i ? CH_W'(NUM_CH - 1) : CH_W'(HALF - 1);
        emit      = sb_q.full[sb_q.slot];
        ovf_set   = '0;

        // slot rotation and registered output
        sb_d.slot      = (sb_q.slot >= last_slot) ? '0 : sb_q.slot + 1'b1;
        sb_d.out_valid = emit;
        sb_d.out_ch    = sb_q.slot;
        sb_d.out_data  = emit ? sb_q.hold[sb_q.slot] : '0;
        if (emit) sb_d.full[sb_q.slot] = 1'b0;

        // capture on the slow phase
        for (int c = 0; c < NUM_CH; c++) begin
            if (slow_en_i && in_valid_i[c] && ch_en_i[c] && (cfg_all_i || c < HALF)) begin
                if (sb_q.full[c] && !(emit && sb_q.slot == CH_W'(c))) ovf_set[c] = 1'b1;
                sb_d.full[c] = 1'b1;
                sb_d.hold[c] = in_data_i[c*SYM_W +: SYM_W];
            end
        end

        sb_d.ovf = (ovf_clr_i ? '0 : sb_q.ovf) | ovf_set;
    end

    always_ff @(posedge clk) begin
        if (rst) sb_q <= '0;
        else     sb_q <= sb_d;
    end

    assign out_valid_o = sb_q.out_valid;
    assign out_ch_o    = sb_q.out_ch;
    assign out_data_o  = sb_q.out_data;
    assign ovf_o       = sb_q.ovf;

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_ch_o != '0) |-> (out_ch_o == $past(out_ch_o) + 1'b1));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !ovf_clr_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

    // R11
    idle_data_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> (out_data_o == '0));
endmodule

// File: rtl/sym_tdm_aggregator.sv
module sym_tdm_aggregator #(
    parameter  int NUM_BLK = 4,
    parameter  int SYM_W   = 8,
    parameter  int ACC_W   = 16,
    localparam int NUM_CH  = NUM_BLK * agg_pkg::CH_PER_BLK,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_all_i,
    input  logic [NUM_CH-1:0]       ch_en_i,
    input  logic [NUM_CH*ACC_W-1:0] rate_inc_i,
    input  logic                    ovf_clr_i,
    input  logic [NUM_CH-1:0]       in_valid_i,
    input  logic [NUM_CH*SYM_W-1:0] in_data_i,
    output logic                    slow_en_o,
    output logic [NUM_CH-1:0]       sym_strobe_o,
    output logic                    out_valid_o,
    output logic [CH_W-1:0]         out_ch_o,
    output logic [SYM_W-1:0]        out_data_o,
    output logic [NUM_CH-1:0]       ovf_o
);
    logic slow_en_w;

    agg_phase #(.DIV(agg_pkg::PHASE_DIV)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .slow_en_o (slow_en_w)
    );

    agg_rate_gen #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .ch_en_i  (ch_en_i),
        .inc_i    (rate_inc_i),
        .strobe_o (sym_strobe_o)
    );

    agg_slot_buf #(.NUM_CH(NUM_CH), .SYM_W(SYM_W), .CH_W(CH_W)) u_slots (
        .clk         (clk),
        .rst         (rst),
        .slow_en_i   (slow_en_w),
        .cfg_all_i   (cfg_all_i),
        .ch_en_i     (ch_en_i),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .ovf_clr_i   (ovf_clr_i),
        .out_valid_o (out_valid_o),
        .out_ch_o    (out_ch_o),
        .out_data_o  (out_data_o),
        .ovf_o       (ovf_o)
    );

    assign slow_en_o = slow_en_w;
endmodule

// File: tb/sym_tdm_aggregator_tb.sv
module sym_tdm_aggregator_tb;
    localparam int NCH = 16;
    localparam int SW  = 8;
    localparam int AW  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_all = 1'b1;
    logic [NCH-1:0]  ch_en = '0;
    logic [NCH*AW-1:0] rate_inc = '0;
    logic            ovf_clr = 1'b0;
    logic [NCH-1:0]  in_valid = '0;
    logic [NCH*SW-1:0] in_data = '0;
    logic            slow_en;
    logic [NCH-1:0]  strobe;
    logic            out_valid;
    logic [3:0]      out_ch;
    logic [SW-1:0]   out_data;
    logic [NCH-1:0]  ovf;

    int nchk = 0;
    int nfail = 0;
    int seen_cnt [NCH];
    logic [SW-1:0] seen_dat [NCH];
    int step_err;
    int range_err;

    always #2.5 clk = ~clk;

    sym_tdm_aggregator #(.NUM_BLK(4), .SYM_W(SW), .ACC_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cfg_all_i(cfg_all), .ch_en_i(ch_en),
        .rate_inc_i(rate_inc), .ovf_clr_i(ovf_clr), .in_valid_i(in_valid),
        .in_data_i(in_data), .slow_en_o(slow_en), .sym_strobe_o(strobe),
        .out_valid_o(out_valid), .out_ch_o(out_ch), .out_data_o(out_data),
        .ovf_o(ovf)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_slow();
        @(negedge clk);
        while (!slow_en) @(negedge clk);
    endtask

    task automatic push(input logic [NCH-1:0] mask, input logic [SW-1:0] base);
        wait_slow();
        for (int c = 0; c < NCH; c++) in_data[c*SW +: SW] = base ^ SW'(c);
        in_valid = mask;
        @(negedge clk);
        in_valid = '0;
    endtask

    // gathers slots from the negedge after the capturing edge onward
    task automatic collect(input int cycles, input int nact);
        logic [3:0] prev;
        bit have_prev;
        have_prev = 0;
        prev = '0;
        step_err = 0;
        range_err = 0;
        for (int c = 0; c < NCH; c++) begin seen_cnt[c] = 0; seen_dat[c] = '0; end
        for (int i = 0; i < cycles; i++) begin
            if (have_prev && int'(out_ch) != (int'(prev) + 1) % nact) step_err++;
            if (int'(out_ch) >= nact) range_err++;
            if (out_valid) begin
                seen_cnt[out_ch]++;
                seen_dat[out_ch] = out_data;
            end
            if (!out_valid && out_data != '0) range_err++;
            prev = out_ch;
            have_prev = 1;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int hits;
        // R1 during reset
        @(negedge clk);
        check(out_valid == 0 && ovf == '0 && strobe == '0 && out_data == '0, "R1 reset outputs", {out_valid, ovf}, 0);
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 0 && ovf == '0 && strobe == '0, "R1 after release", {out_valid, ovf, strobe}, 0);
        // R2 first phase is high right after reset
        check(slow_en == 1'b1, "R2 first slow phase", slow_en, 1);
        hits = 0;
        for (int i = 0; i < 16; i++) begin
            if (slow_en) begin
                hits++;
                if (i % 4 != 0) check(0, "R2 slow phase position", i, 0);
            end
            if (strobe != '0) check(0, "R1 strobe while disabled", strobe, 0);
            @(negedge clk);
        end
        check(hits == 4, "R2 slow phase count", hits, 4);
    endtask

    task automatic t_all_channels();
        bit ok;
        int step_err_all;
        ch_en = '1;
        cfg_all = 1'b1;
        push('1, 8'hA0);
        collect(20, 16);
        ok = 1;
        for (int c = 0; c < NCH; c++)
            if (seen_cnt[c] != 1 || seen_dat[c] != (8'hA0 ^ SW'(c))) begin
                ok = 0;
                check(0, "R4 channel symbol", {seen_cnt[c], seen_dat[c]}, {32'd1, 8'hA0 ^ SW'(c)});
            end
        check(ok, "R4 all sixteen delivered once", ok, 1);
        step_err_all = step_err;
        check(step_err_all == 0, "R3 slot step full mode", step_err_all, 0);
        check(range_err == 0, "R11 idle slot data", range_err, 0);
        check(ovf == '0, "R8 no overflow on single push", ovf, 0);
        check(strobe == '0, "R7 zero increment gives no strobe", strobe, 0);
        // one group of four only
        push(16'h00F0, 8'h11);
        collect(20, 16);
        ok = 1;
        for (int c = 0; c < NCH; c++)
            if (seen_cnt[c] != ((c >= 4 && c < 8) ? 1 : 0)) ok = 0;
        check(ok && seen_dat[6] == (8'h11 ^ 8'h06), "R4 single group burst", seen_dat[6], 8'h17);
    endtask

    task automatic t_off_phase();
        wait_slow();
        @(negedge clk);
        in_data[3*SW +: SW] = 8'h5C;
        in_valid = 16'h0008;
        @(negedge clk);
        in_valid = '0;
        collect(20, 16);
        check(seen_cnt[3] == 0, "R5 off-phase valid ignored", seen_cnt[3], 0);
    endtask

    task automatic t_disabled();
        ch_en = '1;
        ch_en[5] = 1'b0;
        push('1, 8'h40);
        collect(20, 16);
        check(seen_cnt[5] == 0, "R6 disabled channel not output", seen_cnt[5], 0);
        check(seen_cnt[4] == 1 && seen_cnt[6] == 1, "R6 neighbours still output", seen_cnt[4], 1);
        check(ovf == '0, "R6 no overflow from disabled", ovf, 0);
        ch_en = '1;
    endtask

    task automatic t_half_mode();
        bit ok;
        cfg_all = 1'b0;
        repeat (3) @(negedge clk);
        push('1, 8'h70);
        collect(12, 8);
        ok = 1;
        for (int c = 0; c < NCH; c++)
            if (seen_cnt[c] != ((c < 8) ? 1 : 0)) ok = 0;
        check(ok, "R10 half mode lower channels only", ok, 1);
        check(seen_dat[7] == (8'h70 ^ 8'h07), "R4 half mode data", seen_dat[7], 8'h77);
        check(step_err == 0 && range_err == 0, "R3 slot wrap in half mode", step_err + range_err, 0);
        cfg_all = 1'b1;
        repeat (3) @(negedge clk);
        collect(20, 16);
        check(seen_cnt[12] == 0, "R10 upper input stayed ignored", seen_cnt[12], 0);
    endtask

    task automatic t_overflow();
        // three captures 4 cycles apart cannot all be drained in a 16-slot period
        for (int k = 1; k <= 3; k++) begin
            wait_slow();
            in_data[2*SW +: SW] = SW'(k);
            in_valid = 16'h0004;
            @(negedge clk);
            in_valid = '0;
        end
        check(ovf == 16'h0004, "R8 overflow flag on channel 2 only", ovf, 16'h0004);
        collect(20, 16);
        check(seen_dat[2] == 8'h03, "R8 newest symbol kept", seen_dat[2], 3);
        check(ovf == 16'h0004, "R8 flag sticky", ovf, 16'h0004);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf == '0, "R9 clear resets flags", ovf, 0);
    endtask

    task automatic t_strobes();
        int n0, n1, n2, n5, adj;
        logic prev0;
        ch_en = '1;
        ch_en[5] = 1'b0;
        rate_inc = '0;
        rate_inc[0*AW +: AW] = 16'h4000;
        rate_inc[1*AW +: AW] = 16'h1000;
        rate_inc[2*AW +: AW] = 16'h5555;
        rate_inc[5*AW +: AW] = 16'h4000;
        repeat (3) @(negedge clk);
        n0 = 0; n1 = 0; n2 = 0; n5 = 0; adj = 0; prev0 = 1'b0;
        for (int i = 0; i < 96; i++) begin
            n0 += int'(strobe[0]);
            n1 += int'(strobe[1]);
            n2 += int'(strobe[2]);
            n5 += int'(strobe[5]);
            if (prev0 && strobe[0]) adj++;
            prev0 = strobe[0];
            @(negedge clk);
        end
        check(n0 == 24, "R7 quarter increment count", n0, 24);
        check(adj == 0, "R7 strobe is single cycle", adj, 0);
        check(n1 == 6, "R7 sixteenth increment count", n1, 6);
        check(n2 == 31 || n2 == 32, "R7 fractional increment count", n2, 32);
        check(n5 == 0, "R6 disabled channel silent", n5, 0);
        ch_en = '0;
        @(negedge clk);
        @(negedge clk);
        check(strobe == '0, "R1 strobes stop when disabled", strobe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_all_channels();
        t_off_phase();
        t_disabled();
        t_half_mode();
        t_overflow();
        t_strobes();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule